// File: doc/BRIEF.md
# Synchronous serial position reader (master side)

This block drives the clock of a Synchronous Serial Interface and reads position words from a slave. A period timer asks for one read every `cfg_period` system clocks. Each read is a burst of n+1 clock pulses, where n is `cfg_bits`. Each half of a pulse lasts `cfg_half` system clocks.

The slave presents a new bit on every rising edge of the serial clock, and the cable and drivers delay that bit. The block therefore captures each bit a programmable number of system clocks after the rising edge. It assembles the bits most-significant first and presents the finished word with a one-cycle strobe. After the last pulse the slave holds the data line low for a dead time of two serial clock periods. The block waits out that dead time before it can start another burst. At the end of the dead time it checks that the line has returned high.

The controller has four states. The clock is high in IDLE and low in LOW. HIGH is the high half of a pulse, and MONO is the dead time after the burst.

| Transition | From | To | Condition |
|---|---|---|---|
| start | IDLE | LOW | a read request is pending |
| rise | LOW | HIGH | `cfg_half` cycles have passed |
| fall | HIGH | LOW | `cfg_half` cycles have passed and fewer than n+1 rising edges have occurred |
| finish | HIGH | MONO | `cfg_half` cycles have passed and the (n+1)-th rising edge has occurred |
| ready | MONO | IDLE | 4·`cfg_half` cycles have passed; the data line is checked at this edge |

Operating limits:
- `cfg_bits` is between 1 and 32.
- `cfg_half` is at least 1. A value of 0 is treated as 1.
- `cfg_delay`+1 is no more than 2·`cfg_half`.
- `cfg_period` is at least 1.

Top module: `ssi_master_reader`

## Requirements
- R1: `ssi_clk_o` rests at 1 outside bursts. A burst that starts at system clock edge S has exactly n+1 low pulses. At S+t, for t from 0 to 2(n+1)H−1, the clock is 0 when t mod 2H < H, where H is `cfg_half`. It then stays at 1 until the next burst.
- R2: Bit k, for k from 1 to n, is the value of `ssi_data_i` at edge S+(2k−1)H+`cfg_delay`+1. Bit 1 is the most significant bit of the word.
- R3: `word_valid_o` is 1 for exactly one cycle, right after the edge that captures bit n. At that edge `word_o` takes the n captured bits in positions n−1..0, with zeros above them. At no other time does `word_o` change.
- R4: The period timer raises a request at edges P, 2P, 3P, and so on after reset, where P is `cfg_period`. The first burst starts at edge P+1.
- R5: The earliest next burst start is at edge S+(2n+6)H+1. A request that arrives during a burst or its dead time is held. It is served at that earliest start, so the spacing between starts is max(P, (2n+6)H+1).
- R6: At edge S+(2n+6)H, `line_err_o` becomes 1 if `ssi_data_i` is 0 and becomes 0 if it is 1. It holds its value between these edges.
- R7: `period_long_o` is 1 when `cfg_period` is greater than 2,000,000 system clocks, which is 16 ms at 125 MHz, and 0 otherwise. A slave runs asynchronously when it is read less often than that.
- R8: During reset, `ssi_clk_o` is 1, and `word_valid_o`, `word_o`, `line_err_o` and `period_long_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bits | input | 6 | Word length n |
| cfg_half | input | 8 | Length of each half of a serial clock pulse, in system clocks |
| cfg_period | input | 24 | Sampling period, in system clocks |
| cfg_delay | input | 8 | Extra system clocks from a rising edge to the capture |
| ssi_data_i | input | 1 | Serial data from the slave |
| ssi_clk_o | output | 1 | Serial clock, rests high |
| word_o | output | 32 | Last word received, right-justified |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| period_long_o | output | 1 | Sampling period exceeds the synchronous limit |
| line_err_o | output | 1 | Data line was still low at the end of the dead time |

## Verification
The hardest case is a sampling period shorter than one burst plus its dead time. In that case requests arrive while the block is busy and must wait, rather than cut the dead time short. The bench sets a period of 20 cycles against a 91-cycle read. It checks that bursts then start exactly 91 cycles apart, while a cycle-by-cycle model tracks the clock, the strobe and the word.

The line error needs a slave that misbehaves on purpose. The bench's behavioural slave holds the line low ten cycles too long on its first read only. This lets the flag be seen both rising and clearing.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_MONO
    } ssi_state_t;
endpackage

// File: rtl/ssi_period_timer.sv
module ssi_period_timer #(
    parameter int PER_W = 24,
    parameter int LIMIT = 2_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             take_i,
    output logic             req_o,
    output logic             too_long_o
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] last;

    assign last = (cfg_period == '0) ? '0 : cfg_period - PER_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            req_o      <= 1'b0;
            too_long_o <= 1'b0;
        end else begin
            too_long_o <= cfg_period > PER_W'(LIMIT);
            if (take_i)
                req_o <= 1'b0;
            if (cnt >= last) begin
                cnt   <= '0;
                req_o <= 1'b1;
            end else begin
                cnt <= cnt + PER_W'(1);
            end
        end
    end

    // R4: a pending request stays until the controller takes it
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !take_i) |=> req_o);
endmodule

// File: rtl/ssi_burst_fsm.sv
module ssi_burst_fsm
    import ssi_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int BIT_W = 6,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIT_W-1:0] cfg_bits,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             req_i,
    output logic             take_o,
    output logic             data_rise_o,
    output logic             mono_end_o,
    output logic             ssi_clk_o
);
    localparam int PH_W = DIV_W + 2;

    ssi_state_t       state, state_n;
    logic [DIV_W-1:0] half;
    logic [PH_W-1:0]  half_last, mono_last, ph;
    logic [CNT_W-1:0] pcnt, n_ext;

    assign half      = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    assign half_last = PH_W'(half) - PH_W'(1);
    assign mono_last = (PH_W'(half) << 2) - PH_W'(1);
    assign n_ext     = CNT_W'(cfg_bits);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (req_i) state_n = ST_LOW;
            ST_LOW:  if (ph == half_last) state_n = ST_HIGH;
            ST_HIGH: if (ph == half_last)
                         state_n = (pcnt == n_ext + CNT_W'(1)) ? ST_MONO : ST_LOW;
            ST_MONO: if (ph == mono_last) state_n = ST_IDLE;
        endcase
    end

    assign take_o      = (state == ST_IDLE) && req_i;
    assign data_rise_o = (state == ST_LOW) && (ph == half_last) && (pcnt < n_ext);
    assign mono_end_o  = (state == ST_MONO) && (ph == mono_last);

    // state register with phase and pulse counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
            pcnt  <= '0;
        end else begin
            state <= state_n;
            ph    <= (state_n != state || state == ST_IDLE) ? '0 : ph + PH_W'(1);
            if (take_o)
                pcnt <= '0;
            else if (state == ST_LOW && state_n == ST_HIGH)
                pcnt <= pcnt + CNT_W'(1);
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ssi_clk_o <= 1'b1;
        else
            ssi_clk_o <= (state_n != ST_LOW);
    end

    // R1: the line clock rests high whenever the controller is idle
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> ssi_clk_o);
    // R1: never more than n+1 rising edges in a burst
    a_r1_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= n_ext + CNT_W'(1));
    // R5: the dead time always ends in IDLE, never directly in a new burst
    a_r5_no_burst_from_mono: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_MONO) |-> (state != ST_LOW));
endmodule

// File: rtl/ssi_sampler.sv
module ssi_sampler #(
    parameter int MAX_BITS = 32,
    parameter int BIT_W    = 6,
    parameter int DLY_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BIT_W-1:0]    cfg_bits,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic                start_i,
    input  logic                rise_i,
    input  logic                mono_end_i,
    input  logic                sdata_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic                valid_o,
    output logic                line_err_o
);
    localparam int IDX_W = $clog2(MAX_BITS);

    logic                armed, hit, last;
    logic [DLY_W-1:0]    dcnt;
    logic [BIT_W-1:0]    bcnt;
    logic [MAX_BITS-1:0] acc, acc_n;
    logic [IDX_W-1:0]    pos;

    assign hit  = armed && (dcnt == cfg_delay);
    assign pos  = IDX_W'(cfg_bits - bcnt - BIT_W'(1));
    assign last = (bcnt + BIT_W'(1)) == cfg_bits;

    always_comb begin
        acc_n      = acc;
        acc_n[pos] = sdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            dcnt       <= '0;
            bcnt       <= '0;
            acc        <= '0;
            word_o     <= '0;
            valid_o    <= 1'b0;
            line_err_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                acc   <= '0;
                bcnt  <= '0;
                armed <= 1'b0;
            end
            if (hit) begin
                armed <= 1'b0;
                acc   <= acc_n;
                bcnt  <= bcnt + BIT_W'(1);
                if (last) begin
                    word_o  <= acc_n;
                    valid_o <= 1'b1;
                end
            end else if (armed) begin
                dcnt <= dcnt + DLY_W'(1);
            end
            if (rise_i) begin
                armed <= 1'b1;
                dcnt  <= '0;
            end
            if (mono_end_i)
                line_err_o <= !sdata_i;
        end
    end

    // R3: the strobe never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R3: the word changes only together with the strobe
    a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o));
endmodule

// File: rtl/ssi_master_reader.sv
module ssi_master_reader #(
    parameter int MAX_BITS     = 32,
    parameter int DIV_W        = 8,
    parameter int PER_W        = 24,
    parameter int DLY_W        = 8,
    parameter int PERIOD_LIMIT = 2_000_000,
    localparam int BIT_W       = $clog2(MAX_BITS + 1),
    localparam int CNT_W       = $clog2(MAX_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BIT_W-1:0]    cfg_bits,
    input  logic [DIV_W-1:0]    cfg_half,
    input  logic [PER_W-1:0]    cfg_period,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic                ssi_data_i,
    output logic                ssi_clk_o,
    output logic [MAX_BITS-1:0] word_o,
    output logic                word_valid_o,
    output logic                period_long_o,
    output logic                line_err_o
);
    logic req, take, data_rise, mono_end;

    ssi_period_timer #(
        .PER_W (PER_W),
        .LIMIT (PERIOD_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .take_i     (take),
        .req_o      (req),
        .too_long_o (period_long_o)
    );

    ssi_burst_fsm #(
        .DIV_W (DIV_W),
        .BIT_W (BIT_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_bits    (cfg_bits),
        .cfg_half    (cfg_half),
        .req_i       (req),
        .take_o      (take),
        .data_rise_o (data_rise),
        .mono_end_o  (mono_end),
        .ssi_clk_o   (ssi_clk_o)
    );

    ssi_sampler #(
        .MAX_BITS (MAX_BITS),
        .BIT_W    (BIT_W),
        .DLY_W    (DLY_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_bits   (cfg_bits),
        .cfg_delay  (cfg_delay),
        .start_i    (take),
        .rise_i     (data_rise),
        .mono_end_i (mono_end),
        .sdata_i    (ssi_data_i),
        .word_o     (word_o),
        .valid_o    (word_valid_o),
        .line_err_o (line_err_o)
    );
endmodule

// File: tb/test_ssi_master_reader.sv
`timescale 1ns/1ps
module test_ssi_master_reader;
    localparam int LIMIT = 2_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_bits = 6'd8;
    logic [7:0]  cfg_half = 8'd2;
    logic [23:0] cfg_period = 24'd60;
    logic [7:0]  cfg_delay = 8'd2;
    logic        ssi_data = 1'b1;
    logic        ssi_clk;
    logic [31:0] word;
    logic        word_valid, period_long, line_err;

    always #4 clk = ~clk;   // 125 MHz

    ssi_master_reader i_ssi_master_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_bits      (cfg_bits),
        .cfg_half      (cfg_half),
        .cfg_period    (cfg_period),
        .cfg_delay     (cfg_delay),
        .ssi_data_i    (ssi_data),
        .ssi_clk_o     (ssi_clk),
        .word_o        (word),
        .word_valid_o  (word_valid),
        .period_long_o (period_long),
        .line_err_o    (line_err)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // case settings
    int n, H, D, P, L, BL;
    // reference model
    int m_pt, m_bt;
    bit m_pend, m_valid, m_err, m_long, m_clk;
    logic [31:0] m_acc, m_word;
    // start observation
    int ecnt, hi_run, last_start, starts;
    bit obs_prev;
    // behavioural slave
    bit s_prev, s_ready, s_out;
    int s_rc, s_low, s_extra, s_seq;
    logic [31:0] s_word;
    logic q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic sd);
        bit wrap;
        int x;
        wrap = (m_pt >= P - 1);
        m_pt = wrap ? 0 : m_pt + 1;
        m_valid = 1'b0;
        if (m_bt < 0) begin
            if (m_pend) begin
                m_bt = 0;
                m_pend = 1'b0;
                m_acc = '0;
            end
        end else begin
            m_bt++;
            x = m_bt - D - 1;
            if (x >= H && (x - H) % (2 * H) == 0 && (x - H) / (2 * H) < n) begin
                m_acc = {m_acc[30:0], sd};
                if ((x - H) / (2 * H) == n - 1) begin
                    m_valid = 1'b1;
                    m_word = m_acc;
                end
            end
            if (m_bt == BL) begin
                m_err = !sd;
                m_bt = -1;
            end
        end
        if (wrap) m_pend = 1'b1;
        m_long = (P > LIMIT);
        if (m_bt >= 0 && m_bt < (n + 1) * 2 * H)
            m_clk = ((m_bt % (2 * H)) >= H);
        else
            m_clk = 1'b1;
    endtask

    task automatic slave_step();
        logic [31:0] mask;
        bit c;
        c = ssi_clk;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        if (s_prev && !c && s_ready) begin
            s_ready = 1'b0;
            s_word = (32'hA5C3_1E69 ^ (32'(s_seq) * 32'h9E37_79B9)) & mask;
            s_seq++;
            s_rc = 0;
        end
        if (!s_prev && c && !s_ready && s_rc <= n) begin
            s_rc++;
            if (s_rc <= n) begin
                s_out = s_word[n - s_rc];
            end else begin
                s_out = 1'b0;
                s_low = 3 * H + s_extra;
                s_extra = 0;
            end
        end else if (s_low > 0) begin
            s_low--;
            if (s_low == 0) begin
                s_out = 1'b1;
                s_ready = 1'b1;
            end
        end
        s_prev = c;
        q.push_back(s_out);
        while (q.size() > L) ssi_data = q.pop_front();
    endtask

    task automatic step();
        logic sd;
        sd = ssi_data;
        ecnt++;
        model_step(sd);
        chk(ssi_clk == m_clk, "R1 clock", longint'(ssi_clk), longint'(m_clk));
        chk(word_valid == m_valid, "R3 strobe", longint'(word_valid), longint'(m_valid));
        chk(word == m_word, "R2 word", longint'(word), longint'(m_word));
        chk(line_err == m_err, "R6 line error", longint'(line_err), longint'(m_err));
        chk(period_long == m_long, "R7 long period", longint'(period_long), longint'(m_long));
        if (word_valid)   // R2: word matches what the slave latched
            chk(word == s_word, "R2 slave word", longint'(word), longint'(s_word));
        if (obs_prev && !ssi_clk) begin
            if (hi_run > H) begin
                if (starts == 0)
                    chk(ecnt == P + 1, "R4 first start", longint'(ecnt), longint'(P + 1));
                else   // R5 spacing
                    chk(ecnt - last_start == ((P > BL + 1) ? P : BL + 1), "R5 spacing",
                        longint'(ecnt - last_start), longint'((P > BL + 1) ? P : BL + 1));
                starts++;
                last_start = ecnt;
            end
        end
        hi_run = ssi_clk ? hi_run + 1 : 0;
        obs_prev = ssi_clk;
        slave_step();
    endtask

    task automatic run_case(input int bits, input int half, input int dly, input int per,
                            input int lag, input int extra, input int cycles);
        n = bits; H = half; D = dly; P = per; L = lag;
        BL = (2 * n + 6) * H;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_bits = 6'(bits);
        cfg_half = 8'(half);
        cfg_period = 24'(per);
        cfg_delay = 8'(dly);
        m_pt = 0; m_bt = -1; m_pend = 0; m_valid = 0; m_err = 0; m_long = 0;
        m_clk = 1; m_acc = '0; m_word = '0;
        ecnt = 0; hi_run = 100; last_start = 0; starts = 0; obs_prev = 1;
        s_prev = 1; s_ready = 1; s_out = 1; s_rc = 0; s_low = 0; s_extra = extra; s_seq = bits;
        q.delete();
        for (int i = 0; i < lag; i++) q.push_back(1'b1);
        ssi_data = 1'b1;
        repeat (2) @(negedge clk);
        // R8: reset state
        chk(ssi_clk == 1'b1, "R8 clock", longint'(ssi_clk), 1);
        chk(word_valid == 1'b0, "R8 strobe", longint'(word_valid), 0);
        chk(word == 32'd0, "R8 word", longint'(word), 0);
        chk(line_err == 1'b0, "R8 line error", longint'(line_err), 0);
        chk(period_long == 1'b0, "R8 long period", longint'(period_long), 0);
        rst_n = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            step();
        end
        if (per <= LIMIT)   // R1 R4: bursts actually happened
            chk(starts > 1, "R4 bursts seen", longint'(starts), 2);
    endtask

    initial begin
        run_case(8, 2, 2, 60, 2, 0, 400);            // basic
        run_case(12, 3, 5, 20, 3, 0, 600);           // R5 short period deferred, max delay
        run_case(1, 1, 0, 9, 0, 0, 120);             // single bit, fastest clock
        run_case(32, 1, 1, 100, 1, 0, 300);          // full width word
        run_case(4, 2, 1, 100, 0, 10, 350);          // R6 line held low once
        run_case(8, 2, 2, LIMIT + 1, 2, 0, 50);      // R7 period above limit
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule